// File: doc/BRIEF.md
# Bus-Requesting Block Mover

This engine sits on the device side of a shared bus and copies a block of words from the device's buffer into memory. Software loads a descriptor holding a start address, a word count and a transfer style. The engine then asks the bus owner for the bus, waits for the grant, and writes the words to consecutive memory addresses through a valid/ready write port.

There are two transfer styles. In burst style the engine keeps the bus and writes one word after another for as long as the grant stays high. In cycle-steal style it takes one word per bus ownership, and only while the bus is idle. It drops the request after each word and asks again for the next one. When the last word has been accepted, the engine raises an interrupt and holds it until the interrupt is acknowledged.

The device buffer presents its head word on `dev_data`. The engine sends that word to memory unchanged and pulses `dev_take` when the word has been written, so that the buffer can advance.

Top module: `dma_requester`

## Requirements
- R1: After reset, `bus_req`, `mem_valid` and `irq` are low and `desc_ready` is high.
- R2: A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both high. With a nonzero count, `bus_req` is high from the next cycle on. `mem_valid` stays low until a grant has been sampled.
- R3: `mem_valid` rises only in the cycle after an edge at which `bus_req` and `bus_grant` were both high.
- R4: The first write address equals the descriptor address, and each accepted write (`mem_valid` and `mem_ready` both high) adds one to the address. `mem_data` equals `dev_data`. `dev_take` is high exactly in the cycles where a write is accepted.
- R5: Burst style (`desc_burst`=1) with the grant held and `mem_ready` high writes N words in N consecutive cycles. `bus_req` stays high throughout.
- R6: Cycle-steal style (`desc_burst`=0) starts a word only after an edge where the grant is high and `bus_busy` is low. After each accepted word that is not the last, `bus_req` is low for exactly one cycle and then rises again.
- R7: If the grant drops during a burst, the word already presented stays valid until accepted. After that no new word starts and `bus_req` stays high until the grant returns. The block then resumes at the next address.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R9: `irq` rises in the cycle after the last word is accepted. `bus_req` is low from then on. `irq` stays high until an edge with `irq_ack` high and is low in the cycle after that edge.
- R10: `desc_ready` is low from the time a descriptor is taken until the interrupt is acknowledged. A descriptor offered in that time is ignored, and the running block keeps its own addresses and count.
- R11: A descriptor with a word count of zero raises `irq` in the next cycle without ever asserting `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_addr | input | ADDR_W | Start word address |
| desc_count | input | CNT_W | Number of words |
| desc_burst | input | 1 | 1 = burst style, 0 = cycle-steal style |
| desc_ready | output | 1 | Engine idle, descriptor can be taken |
| bus_req | output | 1 | Request for bus ownership |
| bus_grant | input | 1 | Ownership granted by the arbiter |
| bus_busy | input | 1 | Bus in use by another agent |
| mem_valid | output | 1 | Memory write presented |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write word address |
| mem_data | output | DATA_W | Write data |
| dev_data | input | DATA_W | Head word of the device buffer |
| dev_take | output | 1 | Head word consumed |
| irq | output | 1 | Block-complete interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
Every result is one register away from the stimulus that causes it. `bus_req` follows the descriptor edge by one cycle, and `mem_valid` follows the edge that sampled the grant by one cycle. Each word of a burst is presented in the cycle after the previous word is accepted. In cycle-steal style, each following word shows a one-cycle gap with the request low, then one cycle with the request high, before it is presented. `irq` follows the last acceptance by one cycle. The bench drives inputs and reads outputs on the falling edge, so each check falls exactly one rising edge after the input it depends on. The bench also walks through the cycles with no result, such as a withheld grant, a busy bus or a stalled write, and checks that nothing moves there.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_REL,
        ST_DONE
    } dma_state_e;

    typedef struct packed {
        dma_state_e st;
        logic       burst;
    } ctrl_regs_t;

endpackage

// File: rtl/dma_req_cursor.sv
module dma_req_cursor #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
    } cursor_t;

    cursor_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (load) begin
            cur_d.addr   = load_addr;
            cur_d.remain = load_count;
        end else if (step) begin
            cur_d.addr   = cur_q.addr + ADDR_W'(1);
            cur_d.remain = cur_q.remain - ONE_WORD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign addr = cur_q.addr;
    assign last = (cur_q.remain == ONE_WORD);

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dma_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic desc_valid,
    input  logic desc_zero,
    input  logic desc_burst,
    input  logic bus_grant,
    input  logic bus_busy,
    input  logic mem_ready,
    input  logic last_word,
    input  logic irq_ack,
    output logic load,
    output logic step,
    output logic desc_ready,
    output logic bus_req,
    output logic mem_valid,
    output logic irq
);

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        step = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (desc_valid) begin
                    load     = 1'b1;
                    r_d.burst = desc_burst;
                    r_d.st    = desc_zero ? ST_DONE : ST_REQ;
                end
            end
            ST_REQ: begin
                // steal style waits for an idle bus as well as the grant
                if (bus_grant && (r_q.burst || !bus_busy)) begin
                    r_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (mem_ready) begin
                    step = 1'b1;
                    if (last_word) begin
                        r_d.st = ST_DONE;
                    end else if (r_q.burst) begin
                        r_d.st = bus_grant ? ST_XFER : ST_REQ;
                    end else begin
                        r_d.st = ST_REL;
                    end
                end
            end
            ST_REL: begin
                r_d.st = ST_REQ;
            end
            ST_DONE: begin
                if (irq_ack) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.burst <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign desc_ready = (r_q.st == ST_IDLE);
    assign bus_req    = (r_q.st == ST_REQ) || (r_q.st == ST_XFER);
    assign mem_valid  = (r_q.st == ST_XFER);
    assign irq        = (r_q.st == ST_DONE);

endmodule

// File: rtl/dma_requester.sv
module dma_requester #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [CNT_W-1:0]  desc_count,
    input  logic              desc_burst,
    output logic              desc_ready,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              bus_busy,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_take,
    output logic              irq,
    input  logic              irq_ack
);

    logic load;
    logic step;
    logic last_word;
    logic desc_zero;

    assign desc_zero = (desc_count == '0);

    dma_req_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_zero  (desc_zero),
        .desc_burst (desc_burst),
        .bus_grant  (bus_grant),
        .bus_busy   (bus_busy),
        .mem_ready  (mem_ready),
        .last_word  (last_word),
        .irq_ack    (irq_ack),
        .load       (load),
        .step       (step),
        .desc_ready (desc_ready),
        .bus_req    (bus_req),
        .mem_valid  (mem_valid),
        .irq        (irq)
    );

    dma_req_cursor #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_addr  (desc_addr),
        .load_count (desc_count),
        .step       (step),
        .addr       (mem_addr),
        .last       (last_word)
    );

    assign mem_data = dev_data;
    assign dev_take = step;

endmodule

// File: rtl/dma_requester_chk.sv
module dma_requester_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_ready,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              irq,
    input logic              irq_ack
);

    assert_grant_before_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> ($past(bus_grant) && $past(bus_req)));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    assert_irq_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !bus_req);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> (!bus_req && !mem_valid && !irq));

endmodule

bind dma_requester dma_requester_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_ready (desc_ready),
    .bus_req    (bus_req),
    .bus_grant  (bus_grant),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .irq        (irq),
    .irq_ack    (irq_ack)
);

// File: tb/dma_requester_tb.sv
module dma_requester_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam logic [DATA_W-1:0] DBASE = 32'hC0DE_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_valid = 1'b0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [CNT_W-1:0]  desc_count = '0;
    logic              desc_burst = 1'b0;
    logic              desc_ready;
    logic              bus_req;
    logic              bus_grant = 1'b0;
    logic              bus_busy = 1'b0;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic [DATA_W-1:0] dev_data;
    logic              dev_take;
    logic              irq;
    logic              irq_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int words  = 0;
    logic [DATA_W-1:0] dev_idx;

    always #4 clk = ~clk;

    // device buffer model: head word advances on each take
    always_ff @(posedge clk) begin
        if (!rst_n) dev_idx <= '0;
        else if (dev_take) dev_idx <= dev_idx + 1;
    end
    assign dev_data = DBASE + dev_idx;

    dma_requester #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_addr  (desc_addr),
        .desc_count (desc_count),
        .desc_burst (desc_burst),
        .desc_ready (desc_ready),
        .bus_req    (bus_req),
        .bus_grant  (bus_grant),
        .bus_busy   (bus_busy),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .dev_data   (dev_data),
        .dev_take   (dev_take),
        .irq        (irq),
        .irq_ack    (irq_ack)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic give_desc(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n, input logic b);
        desc_addr  = a;
        desc_count = n;
        desc_burst = b;
        desc_valid = 1'b1;
        cyc();
        desc_valid = 1'b0;
    endtask

    task automatic expect_word(input string req, input logic [ADDR_W-1:0] a);
        chk({req, " valid"}, 64'(mem_valid), 64'd1);
        chk({req, " addr (R4)"}, 64'(mem_addr), 64'(a));
        chk({req, " data (R4)"}, 64'(mem_data), 64'(DBASE + DATA_W'(words)));
    endtask

    task automatic finish_irq();
        repeat (3) begin
            cyc();
            chk("R9 irq held", 64'(irq), 64'd1);
        end
        desc_addr  = 16'h7EEE;
        desc_count = 8'd2;
        desc_valid = 1'b1;
        chk("R10 ready low while irq pending", 64'(desc_ready), 64'd0);
        cyc();
        desc_valid = 1'b0;
        chk("R10 descriptor ignored, irq", 64'(irq), 64'd1);
        chk("R10 descriptor ignored, req", 64'(bus_req), 64'd0);
        irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
        chk("R9 irq cleared by ack", 64'(irq), 64'd0);
        chk("R9 ready after ack", 64'(desc_ready), 64'd1);
        cyc();
        chk("R10 no request after ignored descriptor", 64'(bus_req), 64'd0);
    endtask

    task automatic test_reset();
        chk("R1 bus_req", 64'(bus_req), 64'd0);
        chk("R1 mem_valid", 64'(mem_valid), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 desc_ready", 64'(desc_ready), 64'd1);
    endtask

    task automatic test_burst();
        logic [ADDR_W-1:0] a = 16'h0100;
        bus_grant = 1'b0;
        mem_ready = 1'b1;
        give_desc(a, 8'd5, 1'b1);
        chk("R2 request after descriptor", 64'(bus_req), 64'd1);
        chk("R2 no write before grant", 64'(mem_valid), 64'd0);
        // competing descriptor while busy
        desc_addr  = 16'h7777;
        desc_count = 8'd2;
        desc_burst = 1'b0;
        desc_valid = 1'b1;
        chk("R10 ready low while busy", 64'(desc_ready), 64'd0);
        cyc();
        desc_valid = 1'b0;
        chk("R2 no write without grant", 64'(mem_valid), 64'd0);
        repeat (2) begin
            cyc();
            chk("R2 still waiting for grant", 64'(mem_valid), 64'd0);
        end
        bus_grant = 1'b1;
        for (int j = 0; j < 5; j++) begin
            cyc();
            expect_word("R5 burst word", a + ADDR_W'(j));
            chk("R4 take on acceptance", 64'(dev_take), 64'd1);
            chk("R5 request held", 64'(bus_req), 64'd1);
            words++;
        end
        cyc();
        chk("R9 irq after last word", 64'(irq), 64'd1);
        chk("R9 request dropped", 64'(bus_req), 64'd0);
        chk("R9 no write after last", 64'(mem_valid), 64'd0);
        bus_grant = 1'b0;
        finish_irq();
    endtask

    task automatic test_grant_drop();
        logic [ADDR_W-1:0] a = 16'h0200;
        give_desc(a, 8'd4, 1'b1);
        bus_grant = 1'b1;
        mem_ready = 1'b0;
        cyc();
        expect_word("R3 write after grant", a);
        bus_grant = 1'b0;
        cyc();
        expect_word("R8 word held in stall", a);
        chk("R4 no take in stall", 64'(dev_take), 64'd0);
        chk("R7 request held after grant loss", 64'(bus_req), 64'd1);
        mem_ready = 1'b1;
        cyc();
        words++;
        chk("R7 stopped after word in flight", 64'(mem_valid), 64'd0);
        chk("R7 request again", 64'(bus_req), 64'd1);
        cyc();
        chk("R7 waiting for grant", 64'(mem_valid), 64'd0);
        bus_grant = 1'b1;
        for (int j = 1; j < 4; j++) begin
            cyc();
            expect_word("R7 resumed word", a + ADDR_W'(j));
            words++;
        end
        cyc();
        chk("R9 irq after resumed block", 64'(irq), 64'd1);
        bus_grant = 1'b0;
        finish_irq();
    endtask

    task automatic test_steal();
        logic [ADDR_W-1:0] a = 16'h0300;
        give_desc(a, 8'd3, 1'b0);
        bus_grant = 1'b1;
        bus_busy  = 1'b1;
        mem_ready = 1'b1;
        repeat (2) begin
            cyc();
            chk("R6 no word while bus busy", 64'(mem_valid), 64'd0);
        end
        bus_busy = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cyc();
            expect_word("R6 stolen word", a + ADDR_W'(k));
            words++;
            cyc();
            if (k < 2) begin
                chk("R6 request dropped after word", 64'(bus_req), 64'd0);
                chk("R6 no write in gap", 64'(mem_valid), 64'd0);
                cyc();
                chk("R6 request raised again", 64'(bus_req), 64'd1);
                chk("R6 no write while requesting", 64'(mem_valid), 64'd0);
                if (k == 0) begin
                    bus_busy = 1'b1;
                    cyc();
                    chk("R6 busy blocks next word", 64'(mem_valid), 64'd0);
                    chk("R6 request kept while busy", 64'(bus_req), 64'd1);
                    bus_busy = 1'b0;
                end
            end else begin
                chk("R9 irq after stolen block", 64'(irq), 64'd1);
                chk("R9 request low at end", 64'(bus_req), 64'd0);
            end
        end
        bus_grant = 1'b0;
        finish_irq();
    endtask

    task automatic test_zero();
        give_desc(16'h0400, 8'd0, 1'b1);
        chk("R11 irq for empty block", 64'(irq), 64'd1);
        chk("R11 no request for empty block", 64'(bus_req), 64'd0);
        chk("R11 no write for empty block", 64'(mem_valid), 64'd0);
        finish_irq();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        test_reset();
        test_burst();
        test_grant_drop();
        test_steal();
        test_zero();
        repeat (2) cyc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule